// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a run-time configurable two-level logic array. The first plane builds product terms from the inputs. The second plane ORs chosen product terms into each output. Every cross-point in both planes is a stored configuration bit, so any sum-of-products function that fits the term budget can be loaded while the chip is running.

Configuration is written one row per clock through an address and data bus with a write enable. Product rows come first in the address space and output rows follow them. A separate read address returns any stored row so that software-side tooling can verify what was loaded. Evaluation is purely combinational from `dataIn` to `dataOut`.

Each product line is built as a NOR line fed with inverted literals. This makes it an AND of the connected literals. A line with no connections is forced to 0, so spare terms never pull an output high.

Top module: `pla_array`

## Requirements
- R1: After reset every cross-point is cleared: every row reads back 0 and `dataOut` is 0 for every input value.
- R2: In product row t, bit 2i connects the true literal of input i and bit 2i+1 connects its complement. The product term is 1 only when every connected literal is 1, so a row that connects both literals of the same input is always 0.
- R3: A product row with no bits set evaluates to 0.
- R4: Output j is the OR of every product term t whose bit t is set in output row NUM_TERM+j.
- R5: A write with `cfgWe`=1 stores into the row at address `cfgAddr`. Rows 0..NUM_TERM-1 keep the low 2*NUM_IN data bits and rows NUM_TERM..NUM_TERM+NUM_OUT-1 keep the low NUM_TERM data bits. Readback at that address returns the stored bits zero-extended, from the cycle after the write.
- R6: A write changes `dataOut` from the cycle after its clock edge. Without an effective write and with stable inputs, `dataOut` holds its value.
- R7: A write to an address at or above NUM_TERM+NUM_OUT changes no row and no output.
- R8: Reading an address at or above NUM_TERM+NUM_OUT returns 0.
- R9: `dataOut` follows a change on `dataIn` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration storage |
| rstN | input | 1 | Active-low synchronous reset, clears all cross-points |
| cfgWe | input | 1 | Row write enable |
| cfgAddr | input | AW | Row address for writes |
| cfgData | input | DW | Row contents for writes |
| rdAddr | input | AW | Row address for readback |
| rdData | output | DW | Stored row at `rdAddr`, zero-extended |
| dataIn | input | NUM_IN | Logic inputs |
| dataOut | output | NUM_OUT | Sum-of-products outputs |

## Verification
The assertions assume that `dataIn`, `cfgAddr`, `cfgData` and `rdAddr` are steady around each rising clock edge. They also assume that output stability is judged only across cycles in which `dataIn` is unchanged. The stimulus changes every input shortly after a rising edge and compares at the falling edge. The single deliberate mid-cycle input change, used for the combinational path, is made and checked well away from any edge. Addresses beyond the last row are driven on purpose, so the properties on ignored writes and zero readback are reached.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // Decoded configuration strobes passed from control to datapath.
  typedef struct packed {
    logic       termWe;
    logic       sumWe;
    logic [7:0] wrRow;
    logic       termRd;
    logic       sumRd;
    logic [7:0] rdRow;
  } cfgStrobe_t;
endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl
  import pla_pkg::*;
#(
  parameter int NUM_TERM = 6,
  parameter int NUM_OUT  = 3,
  parameter int AW       = 4
) (
  input  logic          cfgWe,
  input  logic [AW-1:0] cfgAddr,
  input  logic [AW-1:0] rdAddr,
  output cfgStrobe_t    strobe
);
  localparam logic [AW:0] TERM_END = (AW+1)'(NUM_TERM);
  localparam logic [AW:0] ROW_END  = (AW+1)'(NUM_TERM + NUM_OUT);

  logic [AW:0] wrWide;
  logic [AW:0] rdWide;

  always_comb begin
    wrWide = {1'b0, cfgAddr};
    rdWide = {1'b0, rdAddr};
    strobe = '0;
    if (wrWide < TERM_END) begin
      strobe.termWe = cfgWe;
      strobe.wrRow  = 8'(wrWide);
    end else if (wrWide < ROW_END) begin
      strobe.sumWe = cfgWe;
      strobe.wrRow = 8'(wrWide - TERM_END);
    end
    if (rdWide < TERM_END) begin
      strobe.termRd = 1'b1;
      strobe.rdRow  = 8'(rdWide);
    end else if (rdWide < ROW_END) begin
      strobe.sumRd = 1'b1;
      strobe.rdRow = 8'(rdWide - TERM_END);
    end
  end
endmodule

// File: rtl/pla_datapath.sv
module pla_datapath
  import pla_pkg::*;
#(
  parameter int NUM_IN   = 4,
  parameter int NUM_TERM = 6,
  parameter int NUM_OUT  = 3,
  parameter int DW       = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfgStrobe_t          strobe,
  input  logic [DW-1:0]       cfgData,
  input  logic [NUM_IN-1:0]   dataIn,
  output logic [NUM_OUT-1:0]  dataOut,
  output logic [DW-1:0]       rdData
);
  localparam int LW = 2 * NUM_IN;

  logic [LW-1:0]       termMask [NUM_TERM];
  logic [NUM_TERM-1:0] sumMask  [NUM_OUT];
  logic [LW-1:0]       literal;
  logic [NUM_TERM-1:0] termVal;

  // Literal columns: even = true input, odd = complemented input.
  for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
    assign literal[2*i]   = dataIn[i];
    assign literal[2*i+1] = ~dataIn[i];
  end

  // Product plane: NOR line over inverted literals, gated by "any connection".
  for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
    logic norLine;
    always_ff @(posedge clk) begin
      if (!rstN)
        termMask[t] <= '0;
      else if (strobe.termWe && strobe.wrRow == 8'(t))
        termMask[t] <= cfgData[LW-1:0];
    end
    assign norLine    = |(termMask[t] & ~literal);
    assign termVal[t] = (|termMask[t]) & ~norLine;
  end

  // Sum plane: OR line over selected product terms.
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_sum
    always_ff @(posedge clk) begin
      if (!rstN)
        sumMask[j] <= '0;
      else if (strobe.sumWe && strobe.wrRow == 8'(j))
        sumMask[j] <= cfgData[NUM_TERM-1:0];
    end
    assign dataOut[j] = |(sumMask[j] & termVal);
  end

  always_comb begin
    rdData = '0;
    for (int t = 0; t < NUM_TERM; t++)
      if (strobe.termRd && strobe.rdRow == 8'(t))
        rdData[LW-1:0] = termMask[t];
    for (int j = 0; j < NUM_OUT; j++)
      if (strobe.sumRd && strobe.rdRow == 8'(j))
        rdData[NUM_TERM-1:0] = sumMask[j];
  end
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter  int NUM_IN   = 4,
  parameter  int NUM_TERM = 6,
  parameter  int NUM_OUT  = 3,
  localparam int ROWS     = NUM_TERM + NUM_OUT,
  localparam int AW       = $clog2(ROWS),
  localparam int LW       = 2 * NUM_IN,
  localparam int DW       = (LW > NUM_TERM) ? LW : NUM_TERM
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [AW-1:0]      cfgAddr,
  input  logic [DW-1:0]      cfgData,
  input  logic [AW-1:0]      rdAddr,
  output logic [DW-1:0]      rdData,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut
);
  cfgStrobe_t strobe;

  pla_ctrl #(.NUM_TERM(NUM_TERM), .NUM_OUT(NUM_OUT), .AW(AW)) ctrl_i (
    .cfgWe  (cfgWe),
    .cfgAddr(cfgAddr),
    .rdAddr (rdAddr),
    .strobe (strobe)
  );

  pla_datapath #(.NUM_IN(NUM_IN), .NUM_TERM(NUM_TERM), .NUM_OUT(NUM_OUT), .DW(DW)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cfgData(cfgData),
    .dataIn (dataIn),
    .dataOut(dataOut),
    .rdData (rdData)
  );
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int NUM_IN   = 4,
  parameter int NUM_TERM = 6,
  parameter int NUM_OUT  = 3,
  parameter int AW       = 4,
  parameter int DW       = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWe,
  input logic [AW-1:0]      cfgAddr,
  input logic [DW-1:0]      cfgData,
  input logic [AW-1:0]      rdAddr,
  input logic [DW-1:0]      rdData,
  input logic [NUM_IN-1:0]  dataIn,
  input logic [NUM_OUT-1:0] dataOut
);
  localparam logic [AW:0]   TERM_END  = (AW+1)'(NUM_TERM);
  localparam logic [AW:0]   ROW_END   = (AW+1)'(NUM_TERM + NUM_OUT);
  localparam logic [DW-1:0] TERM_KEEP = DW'((64'd1 << (2*NUM_IN)) - 64'd1);
  localparam logic [DW-1:0] SUM_KEEP  = DW'((64'd1 << NUM_TERM) - 64'd1);

  logic          wrInRange;
  logic          wrIsTerm;
  logic [DW-1:0] wrKeep;

  assign wrInRange = {1'b0, cfgAddr} < ROW_END;
  assign wrIsTerm  = {1'b0, cfgAddr} < TERM_END;
  assign wrKeep    = wrIsTerm ? TERM_KEEP : SUM_KEEP;

  // R5: readback of a just-written row shows the kept bits.
  assert_write_readback_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && wrInRange) |=>
      ((rdAddr != $past(cfgAddr)) || (rdData == ($past(cfgData) & $past(wrKeep)))));

  // R6 and R7: no effective write plus steady inputs keeps outputs steady.
  assert_output_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWe || !wrInRange) |=> (!$stable(dataIn) || $stable(dataOut)));

  // R7: an out-of-range write leaves the observed row unchanged.
  assert_ignored_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !wrInRange) |=> ((rdAddr != $past(rdAddr)) || $stable(rdData)));

  // R8: rows beyond the array read as zero.
  assert_empty_readback_R8: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, rdAddr} >= ROW_END) |-> (rdData == '0));
endmodule

bind pla_array pla_array_chk #(
  .NUM_IN(NUM_IN), .NUM_TERM(NUM_TERM), .NUM_OUT(NUM_OUT), .AW(AW), .DW(DW)
) chk_i (.*);

// File: tb/pla_array_tb.sv
module pla_array_tb_top;
  localparam int NI = 4, NT = 6, NO = 3, ROWS = NT + NO, AW = 4, DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [AW-1:0] cfgAddr = '0;
  logic [DW-1:0] cfgData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic [NI-1:0] dataIn = '0;
  logic [NO-1:0] dataOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "R1";
  bit done = 0;

  int refTerm [NT];
  int refSum [NO];

  always #4 clk = ~clk;  // 125 MHz

  pla_array dut_i (.*);

  // Reference model: row store updated on each rising edge.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < NT; t++) refTerm[t] <= 0;
      for (int j = 0; j < NO; j++) refSum[j] <= 0;
    end else if (cfgWe && int'(cfgAddr) < ROWS) begin
      if (int'(cfgAddr) < NT) refTerm[int'(cfgAddr)] <= int'(cfgData) & 8'hFF;
      else refSum[int'(cfgAddr) - NT] <= int'(cfgData) & 6'h3F;
    end
  end

  function automatic int refEval(int inVal);
    int res = 0;
    for (int j = 0; j < NO; j++) begin
      for (int t = 0; t < NT; t++) begin
        bit on = (refTerm[t] != 0);
        for (int i = 0; i < NI; i++) begin
          bit v = ((inVal >> i) & 1) != 0;
          if (((refTerm[t] >> (2*i)) & 1) != 0 && !v) on = 0;
          if (((refTerm[t] >> (2*i+1)) & 1) != 0 && v) on = 0;
        end
        if (on && ((refSum[j] >> t) & 1) != 0) res |= (1 << j);
      end
    end
    return res;
  endfunction

  function automatic int refRead(int a);
    if (a < NT) return refTerm[a];
    if (a < ROWS) return refSum[a - NT];
    return 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the rising edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(phase, "dataOut", int'(dataOut), refEval(int'(dataIn)));
      check(phase, "rdData", int'(rdData), refRead(int'(rdAddr)));
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wrRow(int a, int d);
    cfgWe = 1'b1;
    cfgAddr = AW'(a);
    cfgData = DW'(d);
    rdAddr = AW'(a);
    step();
    cfgWe = 1'b0;
  endtask

  task automatic sweep();
    for (int v = 0; v < 16; v++) begin
      dataIn = NI'(v);
      rdAddr = AW'(v);
      step();
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    // R1: cleared array after reset
    phase = "R1";
    sweep();
    // R5 R6: load a function; writes show one cycle later
    phase = "R6";
    wrRow(0, 8'h05);  // a&b
    wrRow(1, 8'h60);  // !c&d
    wrRow(2, 8'h19);  // a&!b&c
    wrRow(3, 8'h82);  // !a&!d
    wrRow(4, 8'h00);  // empty
    wrRow(5, 8'h04);  // b
    phase = "R5";
    wrRow(6, 8'h03);
    wrRow(7, 8'h0C);
    wrRow(8, 8'hF0);  // upper bits discarded, keeps terms 4 and 5
    step();
    check("R5", "sum row trimmed", int'(rdData), 8'h30);
    // R2 R4: exhaustive evaluation
    phase = "R4";
    sweep();
    phase = "R2";
    wrRow(5, 8'h03);  // a and !a: never true
    sweep();
    // R3: terms 4 and 5 empty or contradictory, out2 stays 0
    phase = "R3";
    wrRow(5, 8'h00);
    for (int v = 0; v < 16; v++) begin
      dataIn = NI'(v);
      step();
      check("R3", "out2 from empty terms", int'(dataOut[2]), 0);
    end
    // R7: out-of-range writes ignored
    phase = "R7";
    for (int a = ROWS; a < 16; a++) wrRow(a, 8'hFF);
    sweep();
    // R8: out-of-range readback
    phase = "R8";
    for (int a = ROWS; a < 16; a++) begin
      rdAddr = AW'(a);
      step();
      check("R8", "readback beyond rows", int'(rdData), 0);
    end
    // R9: mid-cycle input change
    phase = "R9";
    for (int v = 0; v < 16; v++) begin
      dataIn = NI'(v);
      #1;
      check("R9", "combinational out", int'(dataOut), refEval(v));
      dataIn = NI'(15 - v);
      #1;
      check("R9", "combinational out", int'(dataOut), refEval(15 - v));
      step();
    end
    finishRun();
  end
endmodule